// File: doc/BRIEF.md
# I2C Register-Write Slave

This block lets an I2C master fill a small bank of byte-wide control registers. It runs from a system clock much faster than SCL. Both bus lines are oversampled on that clock, and START and STOP are recognised from edges of the synchronized signals. The slave answers a single fixed 7-bit device address. It answers only the write direction, and pulls SDA low through an open-drain enable to acknowledge.

A write transaction has three parts: the device address byte, a register pointer byte, and then any number of data bytes. Each data byte is stored at the pointer, after which the pointer advances. After the last register, index 18, the pointer returns to 0. A one-cycle write strobe with the address and data goes out with every store, and the whole bank is always visible on a flat output bus. A STOP or a repeated START ends the current transfer at any bit, and an unfinished byte is dropped.

Top module: `i2c_reg_slave`

## Requirements
- R1: START (SDA falls while SCL is high) begins address reception from any state. STOP (SDA rises while SCL is high) returns the block to idle with SDA released.
- R2: An address byte equal to 0x26 (device address 7'b0010011, then direction bit 0 as the LSB) is acknowledged. Any other address is not acknowledged, and the block ignores every byte until the next START.
- R3: An address byte of 0x27 (direction bit 1, a read) is not acknowledged, and the bus is ignored until the next START.
- R4: The register pointer byte is acknowledged and loaded only when bits 7:5 are zero and its value is at most 0x12. Any other value gets no acknowledge, and the following bytes are ignored until START.
- R5: Each data byte, received MSB first, is acknowledged and stored at the current pointer. A one-cycle wr_stb_o pulse carries the pointer and the byte at the same time.
- R6: After each stored byte the pointer increments by one, and it wraps from 0x12 to 0x00.
- R7: A repeated START in the middle of a byte restarts address reception. The partial byte is discarded and nothing is stored.
- R8: A STOP in the middle of a byte causes no register write.
- R9: The acknowledge enable sda_oe_o rises on the SCL fall after the eighth bit and falls on the SCL fall after the ninth. It rises only while SCL is low.
- R10: Reset clears all 19 registers to zero and holds sda_oe_o and wr_stb_o low.
- R11: Register k appears on regs_o bits [8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge), 0 releases it |
| wr_stb_o | output | 1 | One-cycle pulse for each stored byte |
| wr_addr_o | output | 5 | Register index of the current store |
| wr_data_o | output | 8 | Byte being stored |
| regs_o | output | 152 | All registers, register k at bits [8k+7:8k] |

## Verification
The embedded assertions check on every cycle that the pointer stays within 0..0x12 and that the write strobe is a single-cycle pulse. They also check that it fires only as a data byte is acknowledged, that a strobed byte lands in the addressed register, that the acknowledge enable rises only with SCL low, and that idle never drives SDA. Some behaviour can only be shown by the bench's bus scenarios: the acknowledge decision for each kind of first and second byte, the wrap from 0x12 to 0x00 in a burst, and the discarding of partial bytes on a repeated START or STOP. The same holds for the silence after a rejected byte.

// File: rtl/i2c_regs_pkg.sv
package i2c_regs_pkg;

    localparam int DATA_W = 8;
    localparam int PTR_W  = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } bus_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic              en;
        logic [PTR_W-1:0]  addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p,
                                                  input logic [PTR_W-1:0] last);
        return (p == last) ? '0 : p + PTR_W'(1);
    endfunction

    function automatic logic ptr_byte_ok(input logic [DATA_W-1:0] b,
                                         input logic [PTR_W-1:0] last);
        return (b[DATA_W-1:PTR_W] == '0) && (b[PTR_W-1:0] <= last);
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_regs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic              scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    always_comb begin
        ev.scl      = scl_q[STAGES-1];
        ev.sda      = sda_q[STAGES-1];
        ev.scl_rise = ev.scl & ~scl_d;
        ev.scl_fall = ~ev.scl & scl_d;
        ev.start    = ev.scl & scl_d & sda_d & ~ev.sda;
        ev.stop     = ev.scl & scl_d & ~sda_d & ev.sda;
    end
endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
    import i2c_regs_pkg::*;
#(
    parameter int              NUM_REGS = 19,
    parameter logic [6:0]      DEV_ADDR = 7'b0010011
) (
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    output logic    sda_oe,
    output wr_req_t wr
);
    localparam logic [PTR_W-1:0]  LAST_REG = PTR_W'(NUM_REGS - 1);
    localparam logic [DATA_W-1:0] DEV_BYTE = {DEV_ADDR, 1'b0};

    bus_state_e        state;
    logic [3:0]        bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic [PTR_W-1:0]  ptr;
    logic              accept;
    logic              rx_state;

    always_comb begin
        rx_state = (state == ST_DEV) || (state == ST_PTR) || (state == ST_DATA);
        case (state)
            ST_DEV:  accept = (shreg == DEV_BYTE);
            ST_PTR:  accept = ptr_byte_ok(shreg, LAST_REG);
            ST_DATA: accept = 1'b1;
            default: accept = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
            wr      <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.start) begin
                state   <= ST_DEV;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (ev.stop) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (rx_state) begin
                if (ev.scl_rise && bit_cnt < 4'd8) begin
                    shreg   <= {shreg[DATA_W-2:0], ev.sda};
                    bit_cnt <= bit_cnt + 4'd1;
                end else if (ev.scl_fall && bit_cnt == 4'd8) begin
                    bit_cnt <= '0;
                    if (accept) begin
                        sda_oe <= 1'b1;
                        case (state)
                            ST_DEV:  state <= ST_DEV_ACK;
                            ST_PTR: begin
                                state <= ST_PTR_ACK;
                                ptr   <= shreg[PTR_W-1:0];
                            end
                            default: begin
                                state   <= ST_DATA_ACK;
                                wr.en   <= 1'b1;
                                wr.addr <= ptr;
                                wr.data <= shreg;
                                ptr     <= ptr_step(ptr, LAST_REG);
                            end
                        endcase
                    end else begin
                        state <= ST_SKIP;
                    end
                end
            end else if (ev.scl_fall) begin
                case (state)
                    ST_DEV_ACK:  begin sda_oe <= 1'b0; state <= ST_PTR;  end
                    ST_PTR_ACK:  begin sda_oe <= 1'b0; state <= ST_DATA; end
                    ST_DATA_ACK: begin sda_oe <= 1'b0; state <= ST_DATA; end
                    default: ;
                endcase
            end
        end
    end

    // R6
    ptr_range_chk: assert property (@(posedge clk) disable iff (rst) ptr <= LAST_REG);
    // R5
    stb_pulse_chk: assert property (@(posedge clk) disable iff (rst) wr.en |=> !wr.en);
    // R5
    write_in_ack_chk: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> (state == ST_DATA_ACK) && sda_oe);
    // R9
    oe_rise_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_regs_pkg::*;
#(
    parameter int NUM_REGS = 19
) (
    input  logic                       clk,
    input  logic                       rst,
    input  wr_req_t                    wr,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (wr.en) begin
            for (int k = 0; k < NUM_REGS; k++) begin
                if (wr.addr == PTR_W'(k)) regs[k] <= wr.data;
            end
        end
    end

    assign regs_flat = regs;

    // R5
    bank_store_chk: assert property (@(posedge clk) disable iff (rst)
        wr.en |=> regs[$past(wr.addr)] == $past(wr.data));
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2c_regs_pkg::*;
#(
    parameter int         NUM_REGS    = 19,
    parameter logic [6:0] DEV_ADDR    = 7'b0010011,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe_o,
    output logic                       wr_stb_o,
    output logic [PTR_W-1:0]           wr_addr_o,
    output logic [DATA_W-1:0]          wr_data_o,
    output logic [NUM_REGS*DATA_W-1:0] regs_o
);
    bus_ev_t ev;
    wr_req_t wr;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    i2c_wr_fsm #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst(rst), .ev(ev), .sda_oe(sda_oe_o), .wr(wr)
    );

    i2c_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst(rst), .wr(wr), .regs_flat(regs_o)
    );

    assign wr_stb_o  = wr.en;
    assign wr_addr_o = wr.addr;
    assign wr_data_o = wr.data;
endmodule

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb;
    localparam int N = 19;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe_o, wr_stb_o;
    logic [4:0] wr_addr_o;
    logic [7:0] wr_data_o;
    logic [N*8-1:0] regs_o;

    int vectors = 0;
    int fails = 0;
    logic [12:0] expq[$];
    logic [7:0] model [N];

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe_o;

    i2c_reg_slave u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe_o), .wr_stb_o(wr_stb_o), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .regs_o(regs_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_n(Q);
        scl_m = 1'b1; wait_n(Q);
        sda_m = 1'b0; wait_n(Q);
        scl_m = 1'b0; wait_n(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_n(Q);
        scl_m = 1'b1; wait_n(Q);
        sda_m = 1'b1; wait_n(2*Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    wait_n(Q);
        scl_m = 1'b1; wait_n(2*Q);
        scl_m = 1'b0; wait_n(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        sda_m = 1'b1; wait_n(Q);
        scl_m = 1'b1; wait_n(Q);
        ack = ~sda_line;
        wait_n(Q);
        scl_m = 1'b0; wait_n(Q);
    endtask

    task automatic byte_ack(input logic [7:0] v, input logic exp, input string req);
        logic a;
        send_byte(v, a);
        check(a == exp, req, a, exp);
    endtask

    task automatic data_byte(input logic [7:0] v, inout logic [4:0] p);
        expq.push_back({p, v});
        model[p] = v;
        byte_ack(v, 1'b1, "R5 data ack");
        p = (p == 5'd18) ? 5'd0 : p + 5'd1;
    endtask

    task automatic check_bank(input string req);
        for (int k = 0; k < N; k++)
            check(regs_o[k*8 +: 8] == model[k], req, regs_o[k*8 +: 8], model[k]);
    endtask

    always @(negedge clk) begin
        if (!rst && wr_stb_o) begin
            if (expq.size() == 0) begin
                check(1'b0, "R5 unexpected strobe", {wr_addr_o, wr_data_o}, 0);
            end else begin
                logic [12:0] e;
                e = expq.pop_front();
                check({wr_addr_o, wr_data_o} == e, "R5 strobe addr/data",
                      {wr_addr_o, wr_data_o}, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [4:0] p;
        for (int k = 0; k < N; k++) model[k] = 8'h00;
        wait_n(5);
        rst = 1'b0;
        wait_n(5);
        // R10 reset state, R11 layout
        check(sda_oe_o == 1'b0, "R10 oe after reset", sda_oe_o, 0);
        check(wr_stb_o == 1'b0, "R10 strobe after reset", wr_stb_o, 0);
        check(regs_o == '0, "R10 registers cleared", 0, 0);

        // R1 R2 R9 single write
        bus_start();
        byte_ack(8'h26, 1'b1, "R2 address ack");
        byte_ack(8'h03, 1'b1, "R4 pointer ack");
        check(sda_oe_o == 1'b0, "R9 oe released after ninth clock", sda_oe_o, 0);
        p = 5'd3;
        data_byte(8'hA5, p);
        bus_stop();
        check(sda_oe_o == 1'b0, "R1 idle after stop", sda_oe_o, 0);
        check_bank("R11 single write");

        // R6 burst with wrap 0x12 -> 0x00
        bus_start();
        byte_ack(8'h26, 1'b1, "R2 address ack");
        byte_ack(8'h11, 1'b1, "R4 pointer ack");
        p = 5'd17;
        data_byte(8'h01, p);
        data_byte(8'h02, p);
        data_byte(8'h03, p);
        data_byte(8'h04, p);
        bus_stop();
        check_bank("R6 burst wrap");

        // R2 wrong address
        bus_start();
        byte_ack(8'h24, 1'b0, "R2 wrong address nack");
        byte_ack(8'h05, 1'b0, "R2 ignored after nack");
        byte_ack(8'h55, 1'b0, "R2 ignored after nack");
        bus_stop();
        // R3 read direction
        bus_start();
        byte_ack(8'h27, 1'b0, "R3 read nack");
        byte_ack(8'h05, 1'b0, "R3 ignored after nack");
        bus_stop();
        // R4 bad pointers
        bus_start();
        byte_ack(8'h26, 1'b1, "R2 address ack");
        byte_ack(8'h25, 1'b0, "R4 upper bits set nack");
        byte_ack(8'h66, 1'b0, "R4 ignored after nack");
        bus_stop();
        bus_start();
        byte_ack(8'h26, 1'b1, "R2 address ack");
        byte_ack(8'h13, 1'b0, "R4 pointer past last nack");
        byte_ack(8'h77, 1'b0, "R4 ignored after nack");
        bus_stop();
        check_bank("R4 rejected transfers leave bank");

        // R7 repeated start mid-byte
        bus_start();
        byte_ack(8'h26, 1'b1, "R2 address ack");
        byte_ack(8'h05, 1'b1, "R4 pointer ack");
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_start();
        byte_ack(8'h26, 1'b1, "R7 address after repeated start");
        byte_ack(8'h06, 1'b1, "R7 pointer ack");
        p = 5'd6;
        data_byte(8'h77, p);
        bus_stop();
        check_bank("R7 partial byte dropped");

        // R8 stop mid-byte
        bus_start();
        byte_ack(8'h26, 1'b1, "R2 address ack");
        byte_ack(8'h07, 1'b1, "R4 pointer ack");
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_stop();
        wait_n(Q);
        check_bank("R8 no write on stop");

        check(expq.size() == 0, "R5 all expected strobes seen", expq.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule